// File: doc/BRIEF.md
# Video Line and Frame Timing Generator

This block turns the system clock into the line and frame cadence of a television-rate display. A line lasts a non-integer number of clocks on average, so each line length is taken from a fixed-point phase accumulator with 12 fractional bits. The fractional remainder left over from one line is carried into the next, so over many lines the average period matches the programmed increment exactly. Line lengths differ by at most one clock.

A one-bit standard input selects between a 263-line frame and a 314-line frame, each with its own per-line increment. The block counts lines and frames. It raises a one-clock interrupt pulse when the blanking region starts, and it holds a blanking level for the rest of the frame. It also presents an odd/even field bit, which follows the frame parity only while interlaced display is enabled. The line pulse lasts one clock, so it can serve directly as a clock enable for a timer that counts lines.

Top module: `video_frame_timer`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high, the next state has line 0, frame 0 and fractional remainder 0. `line_pulse`, `vblank_irq`, `vblank` and `field` are all low.
- R2: Line k after reset ends on the clock whose index is floor(P_k/4096) - 1, where clock index 0 is the first clock with `rst` low and P_k is the sum of the increments of lines 0..k. `line_pulse` is high for exactly that one clock.
- R3: `line_num` advances by one after each line pulse. After line total-1 it returns to 0, where total is `LINES_60` (default 263) when the active standard is 0 and `LINES_50` (default 314) when it is 1.
- R4: `frame_cnt` increments by one, modulo 2^FRAME_W, in the same clock edge that returns `line_num` to 0.
- R5: `vblank_irq` is high for exactly one clock: the first clock in which `line_num` equals `VBL_LINE` (default 240).
- R6: `vblank` is high exactly while `line_num` >= `VBL_LINE`.
- R7: `field` equals bit 0 of `frame_cnt` when `interlace_en` is 1, and it is 0 when `interlace_en` is 0.
- R8: `std_active` copies `std_sel` at the clock edge that ends a frame and at every edge while `rst` is high. At all other edges a change on `std_sel` has no effect.
- R9: The per-line increment is `INC_60` (default 8791293, about 2146.31 clocks) when the active standard is 0 and `INC_50` (default 8864320, about 2164.14 clocks) when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| std_sel | input | 1 | Requested standard: 0 = 263-line frame, 1 = 314-line frame |
| interlace_en | input | 1 | Enables the field bit |
| line_pulse | output | 1 | One-clock pulse on the last clock of every line |
| vblank_irq | output | 1 | One-clock pulse when blanking starts |
| vblank | output | 1 | High during the blanking lines |
| field | output | 1 | Current field in interlaced mode |
| line_num | output | LINE_W | Current line within the frame |
| frame_cnt | output | FRAME_W | Frames completed since reset |
| std_active | output | 1 | Standard in force for the current frame |

## Verification
The bench uses small increments with fractional parts far from zero, and short frames, so that many frames pass and the remainder wraps in both standards. It flips `std_sel` in the middle of a frame, and it pulses `std_sel` briefly without reaching a frame boundary. A design that switches standard at once, or that samples the input at the wrong edge, then shows the wrong line total or the wrong line lengths. `interlace_en` is toggled across frames of both parities, which separates a gated field bit from a raw parity bit. A reset is applied in the middle of a run, which shows that the remainder restarts from zero rather than carrying on from before the reset.

// File: rtl/vft_pkg.sv
package vft_pkg;

    typedef enum logic {
        STD_60 = 1'b0,
        STD_50 = 1'b1
    } std_e;

endpackage

// File: rtl/vft_line_phase.sv
module vft_line_phase #(
    parameter int unsigned FRAC_W = 12,
    parameter int unsigned INC_W  = 24,
    parameter int unsigned INC_60 = 8791293,
    parameter int unsigned INC_50 = 8864320
) (
    input  logic          clk,
    input  logic          rst,
    input  vft_pkg::std_e std_q,
    output logic          line_end
);
    localparam int unsigned SUM_W = INC_W + 1;
    localparam int unsigned LEN_W = SUM_W - FRAC_W;
    localparam logic [INC_W-1:0] INC_60_V = INC_W'(INC_60);
    localparam logic [INC_W-1:0] INC_50_V = INC_W'(INC_50);

    typedef struct packed {
        logic [FRAC_W-1:0] frac;
        logic [LEN_W-1:0]  cnt;
    } phase_t;

    phase_t             st_d, st_q;
    logic [INC_W-1:0]   inc;
    logic [SUM_W-1:0]   sum;
    logic [LEN_W-1:0]   len;

    // R9: increment chosen by the standard in force
    always_comb begin
        inc      = (std_q == vft_pkg::STD_50) ? INC_50_V : INC_60_V;
        sum      = SUM_W'(st_q.frac) + SUM_W'(inc);
        len      = sum[SUM_W-1:FRAC_W];
        line_end = (st_q.cnt == len - LEN_W'(1));
        st_d     = st_q;
        if (line_end) begin
            st_d.cnt  = '0;
            st_d.frac = sum[FRAC_W-1:0];   // R2: remainder carried forward
        end else begin
            st_d.cnt  = st_q.cnt + LEN_W'(1);
        end
        if (rst) begin
            st_d = '0;                      // R1
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    a_r2_cnt_in_line: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt < len);

    a_r2_restart_after_end: assert property (@(posedge clk) disable iff (rst)
        line_end |=> (st_q.cnt == '0));

endmodule

// File: rtl/vft_frame_seq.sv
module vft_frame_seq #(
    parameter int unsigned LINE_W   = 9,
    parameter int unsigned FRAME_W  = 16,
    parameter int unsigned LINES_60 = 263,
    parameter int unsigned LINES_50 = 314
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               std_sel,
    input  logic               line_end,
    output logic [LINE_W-1:0]  line_q,
    output logic [FRAME_W-1:0] frame_q,
    output vft_pkg::std_e      std_q,
    output logic               frame_end
);
    localparam logic [LINE_W-1:0] TOT_60 = LINE_W'(LINES_60);
    localparam logic [LINE_W-1:0] TOT_50 = LINE_W'(LINES_50);

    typedef struct packed {
        logic [LINE_W-1:0]  line;
        logic [FRAME_W-1:0] frame;
        vft_pkg::std_e      std;
    } seq_t;

    seq_t              st_d, st_q;
    logic [LINE_W-1:0] total;
    logic [LINE_W-1:0] line_inc;

    always_comb begin
        total     = (st_q.std == vft_pkg::STD_50) ? TOT_50 : TOT_60;
        line_inc  = st_q.line + LINE_W'(1);
        frame_end = line_end && (line_inc == total);
        st_d      = st_q;
        if (frame_end) begin
            st_d.line  = '0;                          // R3
            st_d.frame = st_q.frame + FRAME_W'(1);    // R4
            st_d.std   = vft_pkg::std_e'(std_sel);    // R8
        end else if (line_end) begin
            st_d.line  = line_inc;
        end
        if (rst) begin
            st_d.line  = '0;
            st_d.frame = '0;
            st_d.std   = vft_pkg::std_e'(std_sel);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign line_q  = st_q.line;
    assign frame_q = st_q.frame;
    assign std_q   = st_q.std;

    a_r3_line_in_range: assert property (@(posedge clk) disable iff (rst)
        st_q.line < total);

    a_r3_line_step: assert property (@(posedge clk) disable iff (rst)
        (line_end && !frame_end) |=> (st_q.line == $past(st_q.line) + LINE_W'(1)));

    a_r4_frame_step: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (st_q.frame == $past(st_q.frame) + FRAME_W'(1)));

    a_r8_std_hold: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(st_q.std));

endmodule

// File: rtl/vft_status.sv
module vft_status #(
    parameter int unsigned LINE_W   = 9,
    parameter int unsigned VBL_LINE = 240
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_end,
    input  logic [LINE_W-1:0] line_q,
    input  logic              frame_lsb,
    input  logic              interlace_en,
    output logic              vblank_irq,
    output logic              vblank,
    output logic              field
);
    localparam logic [LINE_W-1:0] VBL_V = LINE_W'(VBL_LINE);

    typedef struct packed {
        logic irq;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d.irq = line_end && ((line_q + LINE_W'(1)) == VBL_V);  // R5
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign vblank_irq = st_q.irq;
    assign vblank     = (line_q >= VBL_V);            // R6
    assign field      = interlace_en & frame_lsb;     // R7

    a_r5_irq_single: assert property (@(posedge clk) disable iff (rst)
        vblank_irq |=> !vblank_irq);

    a_r5_irq_on_line: assert property (@(posedge clk) disable iff (rst)
        vblank_irq |-> (line_q == VBL_V));

    a_r6_rise_with_irq: assert property (@(posedge clk) disable iff (rst)
        $rose(vblank) |-> vblank_irq);

endmodule

// File: rtl/video_frame_timer.sv
module video_frame_timer #(
    parameter int unsigned FRAC_W   = 12,
    parameter int unsigned INC_W    = 24,
    parameter int unsigned INC_60   = 8791293,
    parameter int unsigned INC_50   = 8864320,
    parameter int unsigned LINES_60 = 263,
    parameter int unsigned LINES_50 = 314,
    parameter int unsigned VBL_LINE = 240,
    parameter int unsigned LINE_W   = 9,
    parameter int unsigned FRAME_W  = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               std_sel,
    input  logic               interlace_en,
    output logic               line_pulse,
    output logic               vblank_irq,
    output logic               vblank,
    output logic               field,
    output logic [LINE_W-1:0]  line_num,
    output logic [FRAME_W-1:0] frame_cnt,
    output logic               std_active
);
    vft_pkg::std_e std_q;
    logic          line_end;
    logic          frame_end;

    vft_line_phase #(
        .FRAC_W (FRAC_W),
        .INC_W  (INC_W),
        .INC_60 (INC_60),
        .INC_50 (INC_50)
    ) u_phase (
        .clk      (clk),
        .rst      (rst),
        .std_q    (std_q),
        .line_end (line_end)
    );

    vft_frame_seq #(
        .LINE_W   (LINE_W),
        .FRAME_W  (FRAME_W),
        .LINES_60 (LINES_60),
        .LINES_50 (LINES_50)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .std_sel   (std_sel),
        .line_end  (line_end),
        .line_q    (line_num),
        .frame_q   (frame_cnt),
        .std_q     (std_q),
        .frame_end (frame_end)
    );

    vft_status #(
        .LINE_W   (LINE_W),
        .VBL_LINE (VBL_LINE)
    ) u_status (
        .clk          (clk),
        .rst          (rst),
        .line_end     (line_end),
        .line_q       (line_num),
        .frame_lsb    (frame_cnt[0]),
        .interlace_en (interlace_en),
        .vblank_irq   (vblank_irq),
        .vblank       (vblank),
        .field        (field)
    );

    assign line_pulse = line_end;
    assign std_active = (std_q == vft_pkg::STD_50);

    a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (line_num == '0));

endmodule

// File: tb/video_frame_timer_bench.sv
module video_frame_timer_bench;
    localparam int unsigned T_INC_A = 5 * 4096 + 1229;
    localparam int unsigned T_INC_B = 7 * 4096 + 3000;
    localparam int unsigned T_LA    = 12;
    localparam int unsigned T_LB    = 15;
    localparam int unsigned T_VBL   = 9;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       std_sel = 1'b0;
    logic       interlace_en = 1'b0;
    logic       line_pulse, vblank_irq, vblank, field, std_active;
    logic [8:0] line_num;
    logic [15:0] frame_cnt;

    int n_chk  = 0;
    int n_fail = 0;

    longint m_t, m_phase, m_line, m_frame, m_std, m_irq;

    always #5 clk = ~clk;

    video_frame_timer #(
        .FRAC_W   (12),
        .INC_W    (24),
        .INC_60   (T_INC_A),
        .INC_50   (T_INC_B),
        .LINES_60 (T_LA),
        .LINES_50 (T_LB),
        .VBL_LINE (T_VBL),
        .LINE_W   (9),
        .FRAME_W  (16)
    ) u_video_frame_timer (
        .clk          (clk),
        .rst          (rst),
        .std_sel      (std_sel),
        .interlace_en (interlace_en),
        .line_pulse   (line_pulse),
        .vblank_irq   (vblank_irq),
        .vblank       (vblank),
        .field        (field),
        .line_num     (line_num),
        .frame_cnt    (frame_cnt),
        .std_active   (std_active)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d (t=%0d)", tag, act, exp, m_t);
        end
    endtask

    function automatic longint cur_inc();
        return (m_std != 0) ? longint'(T_INC_B) : longint'(T_INC_A);
    endfunction

    function automatic bit exp_pulse();
        return m_t == ((m_phase + cur_inc()) >>> 12) - 1;
    endfunction

    task automatic compare(input bit in_reset);
        if (in_reset) begin
            // R1: state after reset edges
            chk("R1 line_num",   line_num,   0);
            chk("R1 frame_cnt",  frame_cnt,  0);
            chk("R1 line_pulse", line_pulse, 0);
            chk("R1 vblank_irq", vblank_irq, 0);
            chk("R1 vblank",     vblank,     0);
            chk("R1 field",      field,      0);
            chk("R8 std_active in reset", std_active, m_std);
        end else begin
            chk("R2/R9 line_pulse", line_pulse, exp_pulse());
            chk("R3 line_num",      line_num,   m_line);
            chk("R4 frame_cnt",     frame_cnt,  m_frame);
            chk("R5 vblank_irq",    vblank_irq, m_irq);
            chk("R6 vblank",        vblank,     (m_line >= T_VBL));
            chk("R7 field",         field,      interlace_en ? (m_frame % 2) : 0);
            chk("R8 std_active",    std_active, m_std);
        end
    endtask

    task automatic advance(input bit r);
        longint nl;
        if (r) begin
            m_t = 0; m_phase = 0; m_line = 0; m_frame = 0; m_irq = 0;
            m_std = std_sel;
            return;
        end
        m_irq = 0;
        if (exp_pulse()) begin
            m_phase = m_phase + cur_inc();
            nl = m_line + 1;
            m_irq = (nl == T_VBL);
            if (nl == ((m_std != 0) ? T_LB : T_LA)) begin
                m_line  = 0;
                m_frame = (m_frame + 1) % 65536;
                m_std   = std_sel;
            end else begin
                m_line = nl;
            end
        end
        m_t++;
    endtask

    bit was_reset = 1'b1;

    task automatic run(input int n, input bit r, input bit s, input bit il);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rst = r; std_sel = s; interlace_en = il;
            #1;
            compare(was_reset);
            advance(r);
            was_reset = r;
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        m_std = 0;
        advance(1'b1);
        run(3, 1'b1, 1'b0, 1'b0);
        run(400, 1'b0, 1'b0, 1'b0);
        run(450, 1'b0, 1'b1, 1'b0);
        run(300, 1'b0, 1'b1, 1'b1);
        run(300, 1'b0, 1'b0, 1'b1);
        run(3, 1'b1, 1'b1, 1'b1);
        run(400, 1'b0, 1'b1, 1'b1);
        run(5, 1'b0, 1'b0, 1'b0);
        run(300, 1'b0, 1'b1, 1'b0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule